// File: doc/BRIEF.md
# Condition Flag Unit

This block is the arithmetic and shift stage of a 32-bit datapath, together with the status register that stores its four condition flags. The flags are negative (N), zero (Z), carry (C) and overflow (V). One operation is presented per cycle along with `op_valid`. The result appears combinationally on `result`. The flags register loads on the next rising clock edge.

The flag write is masked in two ways:
- The caller supplies a per-operation update mask.
- The unit clears any flag that the selected operation does not define.

Every flag that is not written keeps its old value for as long as later operations leave it alone. The two compare operations run through the adder exactly as subtract and add do. Their result is shown on `result`, but `result_we` stays low for them.

Top module: `cond_flag_unit`

## Requirements
- R1: Operation code 0 (add) drives `result` = a + b modulo 2^32. C is set when the unsigned sum is at least 2^32. V is set when both operands have the same sign and the sum has the opposite sign.
- R2: Operation code 1 (subtract) drives `result` = a − b modulo 2^32. C is 1 when no borrow occurs, that is when a ≥ b unsigned. V is set when the operands differ in sign and the result's sign differs from a's sign.
- R3: Code 2 (compare) sets the flags exactly as code 1 does, and code 3 (compare-negative) sets them exactly as code 0 does. For both codes, `result_we` is 0. For every other code, `result_we` equals `op_valid`.
- R4: Whenever N or Z is updated, N takes bit 31 of `result`, and Z is 1 exactly when all 32 bits of `result` are zero.
- R5: The shift codes take operand a and the amount `shamt` (0 to 31), and operand b is ignored:
  - 4 is a logical left shift.
  - 5 is a logical right shift.
  - 6 is an arithmetic right shift.
  - 7 is a rotate right.
- R6: For a shift with a non-zero amount, C becomes the last bit moved out of the word. For a rotate, that bit is the new bit 31. A zero amount returns a unchanged and leaves C alone. Shifts never change V.
- R7: `upd_mask` bit 3 enables N, bit 2 enables Z, bit 1 enables C and bit 0 enables V. A flag whose mask bit is 0 keeps its value. The `flags` output uses the same bit order.
- R8: The flags change only on a rising clock edge with `op_valid` high. Otherwise they hold for any number of cycles.
- R9: With `rst_n` low at a rising edge, the flags become 0000, regardless of `op_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe; enables the flag load and the result write |
| op_sel | input | 3 | Operation code 0..7 |
| opnd_a | input | 32 | First operand, or the value to shift |
| opnd_b | input | 32 | Second operand (arithmetic codes only) |
| shamt | input | 5 | Shift amount |
| upd_mask | input | 4 | Flag update enables, {N,Z,C,V} |
| result | output | 32 | Combinational result |
| result_we | output | 1 | Result write enable |
| flags | output | 4 | Registered flags, {N,Z,C,V} |

## Verification
A bad adder or shifter path shows on `result` in the same cycle that the operands are applied. A bad flag input shows on `flags` one edge later. A fault in the masking or hold logic may stay hidden until a later operation leaves a flag untouched and the stale or disturbed value is read. For this reason, the vectors are chained so that every expected flag value depends on the flags left by the previous operation. Zero-amount shifts and masked writes are placed on states in which the untouched flag has a distinctive value.

// File: rtl/cfu_pkg.sv
// Shared definitions for the condition flag unit: operation codes and
// flag bit positions inside the 4-bit status word {N,Z,C,V}.
package cfu_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_CMP = 3'd2,
        OP_CMN = 3'd3,
        OP_LSL = 3'd4,
        OP_LSR = 3'd5,
        OP_ASR = 3'd6,
        OP_ROR = 3'd7
    } cfu_op_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;
    localparam int NFLAG  = 4;
endpackage

// File: rtl/cfu_addsub.sv
// Adder/subtractor for the flag unit.
// Subtraction is a + ~b + 1, so the carry out is 1 when no borrow occurs.
// Overflow compares operand signs against the sign of the sum.
// Assumes: purely combinational, with no registered state.
module cfu_addsub #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] sum,
    output logic          carry,
    output logic          ovf
);
    logic [DW-1:0] b_eff;
    logic [DW:0]   wide;

    // Invert b for subtraction and form the sum one bit wider than the operands.
    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, sub};
        sum   = wide[DW-1:0];
        carry = wide[DW];
        ovf   = (a[DW-1] == b_eff[DW-1]) && (sum[DW-1] != a[DW-1]);
    end
endmodule

// File: rtl/cfu_shifter.sv
// Barrel shifter for the flag unit.
// It produces the shifted word, the last bit moved out, and a valid bit for
// that carry (low when the amount is zero).
// kind: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right.
// Assumes: amt < DW; purely combinational.
module cfu_shifter #(
    parameter int DW = 32,
    parameter int SW = $clog2(DW)
) (
    input  logic [DW-1:0] a,
    input  logic [SW-1:0] amt,
    input  logic [1:0]    kind,
    output logic [DW-1:0] res,
    output logic          cout,
    output logic          cvalid
);
    logic [DW:0]          wide_l;
    logic [DW:0]          wide_r;
    logic signed [DW:0]   ext_s;
    logic [DW:0]          wide_a;
    logic [2*DW-1:0]      dbl;

    // Shift with one guard bit, so that the bit moved out lands in a fixed position.
    always_comb begin
        wide_l = {1'b0, a} << amt;
        wide_r = {a, 1'b0} >> amt;
        ext_s  = $signed({a, 1'b0});
        wide_a = ext_s >>> amt;
        dbl    = {a, a} >> amt;
        cvalid = (amt != '0);
        unique case (kind)
            2'd0: begin res = wide_l[DW-1:0]; cout = wide_l[DW]; end
            2'd1: begin res = wide_r[DW:1];   cout = wide_r[0];  end
            2'd2: begin res = wide_a[DW:1];   cout = wide_a[0];  end
            default: begin res = dbl[DW-1:0]; cout = dbl[DW-1];  end
        endcase
    end
endmodule

// File: rtl/cfu_flag_reg.sv
// Status register for the flag unit.
// Each bit loads its new value only when load is high and its mask bit is set;
// all other bits hold. Synchronous active-low reset clears every bit.
module cfu_flag_reg #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NF-1:0] wmask,
    input  logic [NF-1:0] next,
    output logic [NF-1:0] flags_q
);
    // Masked merge of the new flag values into the held ones.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else if (load) flags_q <= (flags_q & ~wmask) | (next & wmask);
    end

    // R9
    flags_reset_chk: assert property (@(posedge clk) !rst_n |=> flags_q == '0);

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(flags_q));

    for (genvar i = 0; i < NF; i++) begin : g_keep
        // R7
        masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load && !wmask[i] |=> flags_q[i] == $past(flags_q[i]));
    end
endmodule

// File: rtl/cond_flag_unit.sv
// Condition flag unit (top level).
// Selects the adder or shifter result and forms N, Z, C and V.
// It then limits the caller's update mask to the flags that the operation
// defines: arithmetic defines all four; a shift defines N and Z, and C only
// when the amount is non-zero. Compare codes do not raise result_we.
module cond_flag_unit
    import cfu_pkg::*;
#(
    parameter int DW = 32,
    parameter int SW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_sel,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [SW-1:0] shamt,
    input  logic [3:0]    upd_mask,
    output logic [DW-1:0] result,
    output logic          result_we,
    output logic [3:0]    flags
);
    cfu_op_e         op;
    logic            is_arith;
    logic            is_sub;
    logic            is_cmp;
    logic [DW-1:0]   as_sum;
    logic            as_c;
    logic            as_v;
    logic [DW-1:0]   sh_res;
    logic            sh_c;
    logic            sh_cv;
    logic [NFLAG-1:0] flag_new;
    logic [NFLAG-1:0] flag_def;
    logic [NFLAG-1:0] eff_mask;

    // Decode the operation class.
    always_comb begin
        op       = cfu_op_e'(op_sel);
        is_arith = !op_sel[2];
        is_sub   = (op == OP_SUB) || (op == OP_CMP);
        is_cmp   = (op == OP_CMP) || (op == OP_CMN);
    end

    cfu_addsub #(.DW(DW)) addsub_i (
        .a(opnd_a), .b(opnd_b), .sub(is_sub),
        .sum(as_sum), .carry(as_c), .ovf(as_v)
    );

    cfu_shifter #(.DW(DW), .SW(SW)) shift_i (
        .a(opnd_a), .amt(shamt), .kind(op_sel[1:0]),
        .res(sh_res), .cout(sh_c), .cvalid(sh_cv)
    );

    // Result select, write enable, new flag values and the effective mask.
    always_comb begin
        result    = is_arith ? as_sum : sh_res;
        result_we = op_valid && !is_cmp;
        flag_new[FLAG_N] = result[DW-1];
        flag_new[FLAG_Z] = (result == '0);
        flag_new[FLAG_C] = is_arith ? as_c : sh_c;
        flag_new[FLAG_V] = is_arith ? as_v : 1'b0;
        flag_def[FLAG_N] = 1'b1;
        flag_def[FLAG_Z] = 1'b1;
        flag_def[FLAG_C] = is_arith || sh_cv;
        flag_def[FLAG_V] = is_arith;
        eff_mask = upd_mask & flag_def;
    end

    cfu_flag_reg #(.NF(NFLAG)) freg_i (
        .clk(clk), .rst_n(rst_n), .load(op_valid),
        .wmask(eff_mask), .next(flag_new), .flags_q(flags)
    );

    // R3
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd2 || op_sel == 3'd3) |-> !result_we);

    // R4
    n_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && upd_mask[3] |=> flags[3] == $past(result[DW-1]));

    // R4
    z_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && upd_mask[2] |=> flags[2] == $past(result == '0));

    // R6
    shift_zero_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sel[2] && shamt == '0 |=> $stable(flags[1]));

    // R6
    shift_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sel[2] |=> $stable(flags[0]));
endmodule

// File: tb/cond_flag_unit_tb_top.sv
module cond_flag_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_sel;
    logic [31:0] opnd_a, opnd_b;
    logic [4:0]  shamt;
    logic [3:0]  upd_mask;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  flags;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt), .upd_mask(upd_mask),
        .result(result), .result_we(result_we), .flags(flags)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  sh;
        logic [3:0]  mask;
        logic [31:0] res;
        logic        we;
        logic [3:0]  fl;   // expected {N,Z,C,V} after the edge
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 16;
    // Chained: each expected flag word depends on the previous row.
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 32'hFFFFFFFF, 32'h00000001, 5'd0,  4'hF, 32'h00000000, 1'b1, 4'b0110, 4'd1}, // R1 carry, zero
        '{3'd0, 32'h7FFFFFFF, 32'h00000001, 5'd0,  4'hF, 32'h80000000, 1'b1, 4'b1001, 4'd1}, // R1 pos+pos overflow
        '{3'd0, 32'h80000000, 32'h80000000, 5'd0,  4'hF, 32'h00000000, 1'b1, 4'b0111, 4'd1}, // R1 neg+neg overflow
        '{3'd1, 32'h00000005, 32'h00000003, 5'd0,  4'hF, 32'h00000002, 1'b1, 4'b0010, 4'd2}, // R2 no borrow
        '{3'd1, 32'h00000003, 32'h00000005, 5'd0,  4'hF, 32'hFFFFFFFE, 1'b1, 4'b1000, 4'd2}, // R2 borrow
        '{3'd1, 32'h80000000, 32'h00000001, 5'd0,  4'hF, 32'h7FFFFFFF, 1'b1, 4'b0011, 4'd2}, // R2 neg-pos overflow
        '{3'd2, 32'h00000007, 32'h00000007, 5'd0,  4'hF, 32'h00000000, 1'b0, 4'b0110, 4'd3}, // R3 compare equal
        '{3'd3, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0,  4'hF, 32'hFFFFFFFE, 1'b0, 4'b1001, 4'd3}, // R3 compare-negative
        '{3'd4, 32'h80000001, 32'h0000FFFF, 5'd1,  4'hF, 32'h00000002, 1'b1, 4'b0011, 4'd6}, // R6 left carry, V kept
        '{3'd5, 32'h00000001, 32'h0000FFFF, 5'd1,  4'hF, 32'h00000000, 1'b1, 4'b0111, 4'd5}, // R5 right to zero
        '{3'd6, 32'h80000000, 32'h00000000, 5'd31, 4'hF, 32'hFFFFFFFF, 1'b1, 4'b1001, 4'd5}, // R5 arith right
        '{3'd7, 32'h00000001, 32'h00000000, 5'd1,  4'hF, 32'h80000000, 1'b1, 4'b1011, 4'd5}, // R5 rotate
        '{3'd4, 32'h12345678, 32'h00000000, 5'd0,  4'hF, 32'h12345678, 1'b1, 4'b0011, 4'd6}, // R6 zero amount keeps C
        '{3'd1, 32'h00000000, 32'h00000000, 5'd0,  4'hF, 32'h00000000, 1'b1, 4'b0110, 4'd4}, // R4 zero result
        '{3'd0, 32'h00000001, 32'h00000001, 5'd0,  4'h4, 32'h00000002, 1'b1, 4'b0010, 4'd7}, // R7 Z only
        '{3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0,  4'h0, 32'hFFFFFFFE, 1'b1, 4'b0010, 4'd7}  // R7 empty mask
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; checks the comb outputs, then the flags one edge later.
    task automatic run_op(input string req, input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [4:0] sh, input logic [3:0] m, input logic [31:0] eres,
                          input logic ewe, input logic [3:0] efl);
        op_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b; shamt = sh; upd_mask = m;
        #1;
        chk(req, "result", result, eres);
        chk(req, "result_we", {31'd0, result_we}, {31'd0, ewe});
        @(negedge clk);
        chk(req, "flags", {28'd0, flags}, {28'd0, efl});
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0; shamt = '0; upd_mask = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", "flags after reset", {28'd0, flags}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            run_op($sformatf("R%0d", VECS[i].req), VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].sh,
                   VECS[i].mask, VECS[i].res, VECS[i].we, VECS[i].fl);
        end

        // R8: no strobe, flags hold across several edges; R3: no write without strobe
        op_valid = 1'b0; op_sel = 3'd0; opnd_a = 32'h80000000; opnd_b = 32'h80000000; upd_mask = 4'hF;
        #1;
        chk("R3", "result_we without strobe", {31'd0, result_we}, 32'd0);
        repeat (4) @(negedge clk);
        chk("R8", "flags held", {28'd0, flags}, 32'b0010);

        // R6: left shift by 31 moves out bit 1; V kept at 0
        run_op("R6", 3'd4, 32'h00000003, 32'h0, 5'd31, 4'hF, 32'h80000000, 1'b1, 4'b1010);
        // R6: right shift by 31 moves out bit 30
        run_op("R6", 3'd5, 32'h80000000, 32'h0, 5'd31, 4'hF, 32'h00000001, 1'b1, 4'b0000);
        // R7: only C enabled
        run_op("R7", 3'd1, 32'h00000002, 32'h00000001, 5'd0, 4'h2, 32'h00000001, 1'b1, 4'b0010);

        // R9: reset in mid-run wins over a valid operation
        rst_n = 1'b0; op_valid = 1'b1; op_sel = 3'd0; opnd_a = 32'hFFFFFFFF; opnd_b = 32'h1; upd_mask = 4'hF;
        @(negedge clk);
        chk("R9", "flags after mid-run reset", {28'd0, flags}, 32'd0);
        op_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule